// File: doc/BRIEF.md
# Base and Bound Address Relocator

This block sits on the path from a processor's logical address bus to the physical address bus. It keeps two registers, a relocation base and a bound length, so that every user-mode process sees a private logical space starting at address zero. A user access is mapped by adding the base to its logical address. If the logical address reaches or passes the bound, the access is not forwarded to memory and a bus-error fault is raised instead.

The base holds the lowest physical address of the running process, and the bound holds its length. Only supervisor-mode code can load either register, through a small write port. The same mode input that qualifies accesses also qualifies these writes. Supervisor accesses pass through untranslated and unchecked, which gives the operating system a flat view of memory. A user-mode attempt to load either register changes nothing and faults. All results are registered and appear one clock after the request.

Top module: `reloc_xlate`

## Requirements
- R1: After reset, `phys_valid_o` and `fault_o` are 0, and both base and bound are 0. As a result, any user-mode access made right after reset faults.
- R2: A user access (`acc_valid_i`=1, `mode_sup_i`=0) whose logical address is below the bound gives `phys_valid_o`=1, `fault_o`=0 and `phys_addr_o` = logical + base on the next cycle.
- R3: A user access whose logical address is greater than or equal to the bound gives `fault_o`=1 and `phys_valid_o`=0 on the next cycle. Address bound-1 passes and address bound faults.
- R4: The bound comparison is unsigned over the full address width, so an address with its top bit set is never treated as small.
- R5: The base addition wraps modulo 2^AW, where AW defaults to 32.
- R6: A supervisor access (`mode_sup_i`=1) gives `phys_valid_o`=1 and `phys_addr_o` equal to the logical address on the next cycle, with no fault, whatever the base and bound hold.
- R7: A supervisor write (`cfg_wr_i`=1, `mode_sup_i`=1) loads `cfg_wdata_i` into the base when `cfg_sel_i`=0, or into the bound when `cfg_sel_i`=1. The new value applies to accesses from the next cycle on.
- R8: A user-mode write (`cfg_wr_i`=1, `mode_sup_i`=0) leaves both registers unchanged, gives `fault_o`=1 on the next cycle, and suppresses any access made in the same cycle.
- R9: A cycle with no access and no user-mode write gives `phys_valid_o`=0 and `fault_o`=0 on the next cycle.
- R10: `phys_valid_o` and `fault_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sup_i | input | 1 | 1 = supervisor mode, 0 = user mode, for this cycle's access and write |
| acc_valid_i | input | 1 | Logical access request |
| acc_addr_i | input | AW | Logical address |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 0 selects base, 1 selects bound |
| cfg_wdata_i | input | AW | Register write data |
| phys_valid_o | output | 1 | Physical request valid, registered |
| phys_addr_o | output | AW | Physical address, meaningful while `phys_valid_o` is 1 |
| fault_o | output | 1 | Bus-error fault, registered |

## Verification
Every result of this block, whether a mapped address, a pass-through, a fault or an idle cycle, shows up exactly one rising edge after the cycle that caused it. A register write first affects the access made in the following cycle. The driver applies each stimulus at a falling edge and pushes one expected entry per cycle, computed from its own copy of base and bound. The monitor pops that entry just after the next rising edge, so each result is compared in the cycle in which it is due. Addresses are compared only when a valid physical request is expected.

// File: rtl/xl_pkg.sv
package xl_pkg;

    typedef enum logic {
        XL_SEL_BASE  = 1'b0,
        XL_SEL_BOUND = 1'b1
    } xl_sel_e;

endpackage

// File: rtl/xl_bound_regs.sv
module xl_bound_regs #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  xl_pkg::xl_sel_e sel_i,
    input  logic [AW-1:0] wdata_i,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] bound_o
);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] bound;
    } regs_t;

    regs_t regs_d, regs_q;

    // Next-state logic: only a gated write changes the registers.
    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            if (sel_i == xl_pkg::XL_SEL_BASE) begin
                regs_d.base = wdata_i;
            end else begin
                regs_d.bound = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign base_o  = regs_q.base;
    assign bound_o = regs_q.bound;

endmodule

// File: rtl/xl_map.sv
module xl_map #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] logical_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] bound_i,
    output logic [AW-1:0] phys_o,
    output logic          over_o
);

    // One adder and one comparator; both work modulo 2^AW and unsigned.
    always_comb begin
        phys_o = logical_i + base_i;
        over_o = (logical_i >= bound_i);
    end

endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sup_i,
    input  logic          acc_valid_i,
    input  logic [AW-1:0] acc_addr_i,
    input  logic          cfg_wr_i,
    input  logic          cfg_sel_i,
    input  logic [AW-1:0] cfg_wdata_i,
    output logic          phys_valid_o,
    output logic [AW-1:0] phys_addr_o,
    output logic          fault_o
);

    typedef struct packed {
        logic          vld;
        logic          flt;
        logic [AW-1:0] addr;
    } out_t;

    logic          sup_wr;
    logic          usr_wr;
    logic [AW-1:0] base_q;
    logic [AW-1:0] bound_q;
    logic [AW-1:0] mapped;
    logic          over;
    out_t          out_d, out_q;

    assign sup_wr = cfg_wr_i &  mode_sup_i;
    assign usr_wr = cfg_wr_i & ~mode_sup_i;

    xl_bound_regs #(.AW(AW)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (sup_wr),
        .sel_i   (xl_pkg::xl_sel_e'(cfg_sel_i)),
        .wdata_i (cfg_wdata_i),
        .base_o  (base_q),
        .bound_o (bound_q)
    );

    xl_map #(.AW(AW)) i_map (
        .logical_i (acc_addr_i),
        .base_i    (base_q),
        .bound_i   (bound_q),
        .phys_o    (mapped),
        .over_o    (over)
    );

    always_comb begin
        out_d     = out_q;
        out_d.flt = usr_wr | (acc_valid_i & ~mode_sup_i & over);
        out_d.vld = acc_valid_i & ~out_d.flt;
        if (out_d.vld) begin
            out_d.addr = mode_sup_i ? acc_addr_i : mapped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign phys_valid_o = out_q.vld;
    assign fault_o      = out_q.flt;
    assign phys_addr_o  = out_q.addr;

endmodule

// File: rtl/xl_checker.sv
module xl_checker #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_sup_i,
    input logic          acc_valid_i,
    input logic [AW-1:0] acc_addr_i,
    input logic          cfg_wr_i,
    input logic          phys_valid_o,
    input logic [AW-1:0] phys_addr_o,
    input logic          fault_o,
    input logic [AW-1:0] base_q,
    input logic [AW-1:0] bound_q
);

    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(phys_valid_o && fault_o));

    assert_over_faults_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && !mode_sup_i && acc_addr_i >= bound_q)
        |=> (fault_o && !phys_valid_o));

    assert_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && !mode_sup_i && !cfg_wr_i && acc_addr_i < bound_q)
        |=> (phys_valid_o && phys_addr_o == $past(acc_addr_i + base_q)));

    assert_sup_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && mode_sup_i)
        |=> (phys_valid_o && !fault_o && phys_addr_o == $past(acc_addr_i)));

    assert_usr_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && !mode_sup_i)
        |=> (fault_o && !phys_valid_o && $stable(base_q) && $stable(bound_q)));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid_i && !(cfg_wr_i && !mode_sup_i))
        |=> (!phys_valid_o && !fault_o));

endmodule

bind reloc_xlate xl_checker #(.AW(AW)) i_xl_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sup_i   (mode_sup_i),
    .acc_valid_i  (acc_valid_i),
    .acc_addr_i   (acc_addr_i),
    .cfg_wr_i     (cfg_wr_i),
    .phys_valid_o (phys_valid_o),
    .phys_addr_o  (phys_addr_o),
    .fault_o      (fault_o),
    .base_q       (base_q),
    .bound_q      (bound_q)
);

// File: tb/test_reloc_xlate.sv
module test_reloc_xlate;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    typedef struct {
        logic          vld;
        logic          flt;
        logic [AW-1:0] addr;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_sup_i = 1'b0;
    logic          acc_valid_i = 1'b0;
    logic [AW-1:0] acc_addr_i = '0;
    logic          cfg_wr_i = 1'b0;
    logic          cfg_sel_i = 1'b0;
    logic [AW-1:0] cfg_wdata_i = '0;
    logic          phys_valid_o;
    logic [AW-1:0] phys_addr_o;
    logic          fault_o;

    exp_t          q[$];
    logic [AW-1:0] m_base = '0;
    logic [AW-1:0] m_bound = '0;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reloc_xlate #(.AW(AW)) i_reloc_xlate (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sup_i   (mode_sup_i),
        .acc_valid_i  (acc_valid_i),
        .acc_addr_i   (acc_addr_i),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_sel_i    (cfg_sel_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .phys_valid_o (phys_valid_o),
        .phys_addr_o  (phys_addr_o),
        .fault_o      (fault_o)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Driver: applies one cycle of stimulus at a falling edge and queues
    // the result expected after the next rising edge.
    task automatic step(input logic sup, input logic av, input logic [AW-1:0] a,
                        input logic wr, input logic sel, input logic [AW-1:0] wd,
                        input string tag);
        exp_t e;
        @(negedge clk);
        mode_sup_i  = sup;
        acc_valid_i = av;
        acc_addr_i  = a;
        cfg_wr_i    = wr;
        cfg_sel_i   = sel;
        cfg_wdata_i = wd;
        e.tag  = tag;
        e.addr = '0;
        e.flt  = (wr && !sup) || (av && !sup && a >= m_bound);
        e.vld  = av && !e.flt;
        if (e.vld) e.addr = sup ? a : a + m_base;
        q.push_back(e);
        if (wr && sup) begin
            if (sel) m_bound = wd;
            else     m_base  = wd;
        end
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, tag);
    endtask

    // Monitor: pops one entry per cycle, just after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (phys_valid_o !== e.vld || fault_o !== e.flt ||
                    (e.vld && phys_addr_o !== e.addr)) begin
                    n_fail++;
                    $display("FAIL %s: vld=%0b flt=%0b addr=%h expected vld=%0b flt=%0b addr=%h",
                             e.tag, phys_valid_o, fault_o, phys_addr_o, e.vld, e.flt, e.addr);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 3);
        n_chk++;
        if (phys_valid_o !== 1'b0 || fault_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: vld=%0b flt=%0b expected 0 0", phys_valid_o, fault_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        idle("R1 idle after reset");
        step(1'b0, 1'b1, 32'h0, 1'b0, 1'b0, '0, "R1 user access with zero bound");
        // R7 supervisor loads base then bound
        step(1'b1, 1'b0, '0, 1'b1, 1'b0, 32'h0000_1000, "R7 load base");
        step(1'b1, 1'b0, '0, 1'b1, 1'b1, 32'h0000_0100, "R7 load bound");
        step(1'b0, 1'b1, 32'h0, 1'b0, 1'b0, '0, "R2 map address 0");
        step(1'b0, 1'b1, 32'h0000_00FF, 1'b0, 1'b0, '0, "R3 bound-1 passes");
        step(1'b0, 1'b1, 32'h0000_0100, 1'b0, 1'b0, '0, "R3 bound faults");
        step(1'b0, 1'b1, 32'h8000_0000, 1'b0, 1'b0, '0, "R4 unsigned compare");
        step(1'b1, 1'b1, 32'h1234_5678, 1'b0, 1'b0, '0, "R6 supervisor bypass");
        step(1'b0, 1'b1, 32'h0000_0040, 1'b0, 1'b0, '0, "R2 map mid range");
        // R8 user writes are refused
        step(1'b0, 1'b0, '0, 1'b1, 1'b0, 32'h0000_DEAD, "R8 user base write faults");
        step(1'b0, 1'b1, 32'h0000_0010, 1'b0, 1'b0, '0, "R8 base unchanged");
        step(1'b0, 1'b0, '0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R8 user bound write faults");
        step(1'b0, 1'b1, 32'h0000_0200, 1'b0, 1'b0, '0, "R8 bound unchanged");
        step(1'b0, 1'b1, 32'h0000_0010, 1'b1, 1'b1, 32'hFFFF_FFFF, "R8 write suppresses access");
        idle("R9 idle");
        // R5 wrap of the addition
        step(1'b1, 1'b0, '0, 1'b1, 1'b0, 32'hFFFF_FF00, "R7 load high base");
        step(1'b1, 1'b0, '0, 1'b1, 1'b1, 32'h0000_1000, "R7 load larger bound");
        step(1'b0, 1'b1, 32'h0000_0200, 1'b0, 1'b0, '0, "R5 wrapped sum");
        step(1'b0, 1'b1, 32'h0000_0FFF, 1'b0, 1'b0, '0, "R3 new bound-1");
        // R7 new base applies to the very next access
        step(1'b1, 1'b0, '0, 1'b1, 1'b0, 32'h0000_5000, "R7 reload base");
        step(1'b0, 1'b1, 32'h0000_0004, 1'b0, 1'b0, '0, "R7 next cycle uses new base");
        step(1'b1, 1'b1, 32'hFFFF_FFF0, 1'b0, 1'b0, '0, "R6 supervisor high address");
        idle("R9 idle end");
        idle("R9 idle end 2");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule